// File: doc/BRIEF.md
# Nine-Bit Serial Command Writer

This block is a transmit-only serial master for display controllers whose serial port takes 9-bit words. The top bit of each word says how to read the low byte. A cleared flag marks a command (register) byte. A set flag marks a parameter byte. One request carries a command byte, a parameter count and up to sixteen bits of parameter data. The block sends the command word and then zero, one or two parameter words. All of them go out inside a single chip-select frame. A one-cycle completion pulse ends each request.

The serial clock idles high, and the receiver samples on its rising edge. The transmit data changes only while the clock is low. The serial rate is set by a half-period input given in system clocks. The block latches it when it accepts a request.

The control is one state machine with six states:
- `ST_IDLE`: waiting for a request.
- `ST_LEAD`: chip select is low, the clock is still high and the first bit is on the data line.
- `ST_LOW`: clock-low half of a bit.
- `ST_HIGH`: clock-high half of a bit.
- `ST_GUARD`: chip select is back high for one full serial period.
- `ST_FINISH`: the completion cycle.

The transitions are:
- accept: `ST_IDLE` to `ST_LEAD` when a request arrives.
- first edge: `ST_LEAD` to `ST_LOW`.
- rise: `ST_LOW` to `ST_HIGH`.
- next bit: `ST_HIGH` to `ST_LOW` while bits remain.
- last bit: `ST_HIGH` to `ST_GUARD`.
- release: `ST_GUARD` to `ST_FINISH`.
- return: `ST_FINISH` to `ST_IDLE`.

Every timed state lasts until a shared phase counter expires.

Top module: `nine_bit_spi_writer`

## Requirements
- R1: Every word is 9 bits, shifted most-significant bit first. The first word of a request is the command word: bit 8 = 0, bits 7:0 = `req_cmd`.
- R2: Every parameter word has bit 8 = 1, with the parameter byte in bits 7:0.
- R3: `req_nparam` = 0 sends 1 word, 1 sends 2 words and 2 sends 3 words. The value 3 is treated as 2.
- R4: With two parameters, the first parameter word carries `req_param[15:8]` and the second carries `req_param[7:0]`. With one parameter, the parameter word carries `req_param[7:0]`.
- R5: The serial clock is high whenever chip select is high. The data line only changes while the serial clock is low, so it is valid at every rising edge.
- R6: Consecutive rising edges of `spi_sclk` within a frame are exactly 2*H system cycles apart. H is `div_half` as latched at acceptance, and a value of 0 acts as 1.
- R7: Chip select stays low across all words of a request. It is high for at least 2*H system cycles after the last bit before `done` pulses.
- R8: `busy` rises in the cycle after a request is accepted and stays high through the `done` cycle. It is high for H*(18*W+3)+1 cycles, where W is the number of words.
- R9: `done` is a single-cycle pulse, issued exactly once per accepted request.
- R10: A request presented while `busy` is high is ignored. The frame in flight is unchanged and no further frame follows.
- R11: After reset: `spi_cs_n` = 1, `spi_sclk` = 1, `spi_mosi` = 0, `busy` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_cmd | input | 8 | Command (register) byte |
| req_nparam | input | 2 | Parameter count 0..2 (3 acts as 2) |
| req_param | input | 16 | Parameter data, high byte first when two are sent |
| div_half | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |

## Verification
The assertions assume that `rst_n` is held low until the clock runs. They also assume that `req_valid` is the only thing that can start a frame, so every rise of `busy` must follow a strobe.

The stimulus never changes `div_half` while a frame is in flight, although the design latches it anyway. It drives every request and every intruding strobe on the falling clock edge. It sweeps each half-period from 0 to 3 against every parameter count and several byte patterns, so every word mix meets every rate.

// File: rtl/nbw_pkg.sv
package nbw_pkg;

    localparam int WORD_W    = 9;
    localparam int MAX_WORDS = 3;
    localparam int FRAME_W   = WORD_W * MAX_WORDS;
    localparam int BITCNT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GUARD,
        ST_FINISH
    } nbw_state_t;

    // Left-justified frame: flag bit ahead of each byte, unused words zero.
    function automatic logic [FRAME_W-1:0] pack_frame(
        input logic [7:0]  cmd,
        input logic [1:0]  nparam,
        input logic [15:0] param
    );
        logic [FRAME_W-1:0] f;
        if (nparam == 2'd0)
            f = {1'b0, cmd, {(2*WORD_W){1'b0}}};
        else if (nparam == 2'd1)
            f = {1'b0, cmd, 1'b1, param[7:0], {WORD_W{1'b0}}};
        else
            f = {1'b0, cmd, 1'b1, param[15:8], 1'b1, param[7:0]};
        return f;
    endfunction

    function automatic logic [BITCNT_W-1:0] frame_bits(input logic [1:0] nparam);
        logic [BITCNT_W-1:0] n;
        if (nparam == 2'd0)
            n = BITCNT_W'(WORD_W);
        else if (nparam == 2'd1)
            n = BITCNT_W'(2 * WORD_W);
        else
            n = BITCNT_W'(3 * WORD_W);
        return n;
    endfunction

endpackage

// File: rtl/nbw_phase_timer.sv
module nbw_phase_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/nbw_shifter.sv
module nbw_shifter
    import nbw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [FRAME_W-1:0]  frame,
    input  logic [BITCNT_W-1:0] nbits,
    input  logic                shift,
    output logic                bit_out,
    output logic                last_bit
);

    logic [FRAME_W-1:0]  sr;
    logic [BITCNT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
        end else if (load) begin
            sr   <= frame;
            left <= nbits;
        end else if (shift) begin
            sr   <= {sr[FRAME_W-2:0], 1'b0};
            left <= left - BITCNT_W'(1);
        end
    end

    assign bit_out  = sr[FRAME_W-1];
    assign last_bit = (left == BITCNT_W'(1));

endmodule

// File: rtl/nine_bit_spi_writer.sv
module nine_bit_spi_writer
    import nbw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_cmd,
    input  logic [1:0]       req_nparam,
    input  logic [15:0]      req_param,
    input  logic [DIV_W-1:0] div_half,
    output logic             busy,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi
);

    localparam int CNT_W = DIV_W + 1;

    nbw_state_t state, state_nx;

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] half_q;
    logic [CNT_W-1:0] half_m1_now;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] full_m1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_bit;
    logic             sh_last;

    assign half_eff    = (div_half == '0) ? DIV_W'(1) : div_half;
    assign half_m1_now = CNT_W'(half_eff) - CNT_W'(1);
    assign half_m1     = CNT_W'(half_q) - CNT_W'(1);
    assign full_m1     = {half_q, 1'b0} - CNT_W'(1);

    nbw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    nbw_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .frame    (pack_frame(req_cmd, req_nparam, req_param)),
        .nbits    (frame_bits(req_nparam)),
        .shift    (sh_shift),
        .bit_out  (sh_bit),
        .last_bit (sh_last)
    );

    // State register and the latched rate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            half_q <= DIV_W'(1);
        end else begin
            state <= state_nx;
            if (sh_load)
                half_q <= half_eff;
        end
    end

    // Transitions and datapath control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = half_m1;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = half_m1_now;
                    sh_load  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_done) begin
                    state_nx = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    state_nx = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        state_nx = ST_GUARD;
                        tmr_val  = full_m1;
                    end else begin
                        state_nx = ST_LOW;
                        sh_shift = 1'b1;
                    end
                end
            end
            ST_GUARD: begin
                if (tmr_done)
                    state_nx = ST_FINISH;
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        logic framing;
        framing  = (state == ST_LEAD) || (state == ST_LOW) || (state == ST_HIGH);
        spi_cs_n = !framing;
        spi_sclk = (state != ST_LOW);
        spi_mosi = framing ? sh_bit : 1'b0;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
    end

endmodule

// File: rtl/nbw_checker.sv
module nbw_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);

    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk);

    a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sclk && $past(!spi_cs_n && spi_sclk)) |-> $stable(spi_mosi));

    a_r7_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    a_r8_done_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r8_busy_ends_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

bind nine_bit_spi_writer nbw_checker u_nbw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/nine_bit_spi_writer_test.sv
`timescale 1ns/1ps
module nine_bit_spi_writer_test;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [7:0]       req_cmd = '0;
    logic [1:0]       req_nparam = '0;
    logic [15:0]      req_param = '0;
    logic [DIV_W-1:0] div_half = '0;
    logic             busy, done, spi_cs_n, spi_sclk, spi_mosi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // slave model
    int          rx_bits = 0;
    logic [26:0] rx_val = '0;
    int          frames = 0;
    int          last_rise = -1;
    int          per_min = 0;
    int          per_max = 0;

    always #2 clk = ~clk;

    always @(negedge clk) cyc = cyc + 1;

    nine_bit_spi_writer #(.DIV_W(DIV_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .req_nparam (req_nparam),
        .req_param  (req_param),
        .div_half   (div_half),
        .busy       (busy),
        .done       (done),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi)
    );

    always @(negedge spi_cs_n) begin
        rx_bits   = 0;
        rx_val    = '0;
        last_rise = -1;
        per_min   = 1 << 30;
        per_max   = 0;
    end

    always @(posedge spi_cs_n) if (rst_n) frames = frames + 1;

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            rx_val  = {rx_val[25:0], spi_mosi};
            rx_bits = rx_bits + 1;
            if (last_rise >= 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            last_rise = cyc;
        end
    end

    task automatic check(input string req, input longint actual, input longint expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic run_req(input int h, input logic [1:0] n, input logic [7:0] cmd,
                           input logic [15:0] par);
        int heff, words, busy_cnt, done_cnt, gap, f0;
        logic [26:0] expv;
        heff  = (h == 0) ? 1 : h;
        words = (n == 2'd0) ? 1 : (n == 2'd1) ? 2 : 3;
        if (n == 2'd0)      expv = 27'({1'b0, cmd});
        else if (n == 2'd1) expv = 27'({1'b0, cmd, 1'b1, par[7:0]});
        else                expv = {1'b0, cmd, 1'b1, par[15:8], 1'b1, par[7:0]};
        f0 = frames;

        @(negedge clk);
        div_half   = DIV_W'(h);
        req_cmd    = cmd;
        req_nparam = n;
        req_param  = par;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        busy_cnt = 0; done_cnt = 0; gap = 0;
        while (busy && busy_cnt < 5000) begin
            busy_cnt++;
            if (done) done_cnt++;
            if (spi_cs_n) gap++;
            // R10: intruding request while busy
            if (busy_cnt == 3) begin
                req_cmd    = ~cmd;
                req_nparam = 2'd2;
                req_param  = ~par;
                req_valid  = 1'b1;
            end else begin
                req_valid  = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;

        check("R1/R3 bit count", rx_bits, 9 * words);
        check("R1/R2/R4/R5 frame content", rx_val, expv);
        check("R6 min sclk period", per_min, 2 * heff);
        check("R6 max sclk period", per_max, 2 * heff);
        check("R8 busy length", busy_cnt, heff * (18 * words + 3) + 1);
        check("R9 done pulses", done_cnt, 1);
        check("R7 guard at least 2H", (gap >= 2 * heff) ? 1 : 0, 1);
        repeat (8 * heff + 4) @(negedge clk);
        check("R10 single frame", frames - f0, 1);
        check("R5 idle sclk high", spi_sclk, 1);
        check("R10 idle after ignored request", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 cs_n", spi_cs_n, 1);
        check("R11 sclk", spi_sclk, 1);
        check("R11 mosi", spi_mosi, 0);
        check("R11 busy", busy, 0);
        check("R11 done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int h = 0; h < 4; h++) begin
            for (int n = 0; n < 4; n++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0]  c;
                    logic [15:0] d;
                    c = (p == 0) ? 8'h00 : (p == 1) ? 8'hff : (8'ha5 ^ 8'(n * 17 + h));
                    d = (p == 0) ? 16'h0000 : (p == 1) ? 16'hffff : (16'h5a3c ^ 16'(h << 4));
                    run_req(h, 2'(n), c, d);
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule